// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

A shift and rotate datapath for a 64-bit integer pipeline. It takes a 64-bit operand, a 5-bit immediate, a 64-bit amount register and a 4-bit operation code. It returns the 64-bit result of a logical left shift, a logical right shift, an arithmetic right shift or a right rotate. Each of the four operations comes in three forms. The immediate form shifts by the immediate. The offset form shifts by the immediate plus 32. The variable form shifts by the low six bits of the amount register.

All twelve operations share one right-rotating barrel network. A left shift by n is a right rotate by (64 − n) mod 64. A zero mask then clears the bits that wrapped around, and a sign fill handles the arithmetic case. With the default parameter setting the result is registered, so it appears one clock after the inputs are sampled. Setting `REG_OUT` to 0 makes the unit purely combinational.

Top module: `shift_rot64_unit`

## Requirements
- R1: Operation code `op_i[1:0]` = 00 selects the immediate form: the shift distance is `imm_i` (0 to 31).
- R2: `op_i[1:0]` = 01 selects the offset form: the shift distance is `imm_i` + 32 (32 to 63).
- R3: `op_i[1:0]` = 10 selects the variable form: the shift distance is `amt_reg_i[5:0]`, and bits 63:6 of `amt_reg_i` have no effect on the result.
- R4: In every form the value that is shifted is `data_i`. The amount register never supplies the shifted value.
- R5: `op_i[3:2]` = 01 is a logical right shift: vacated upper bits become 0.
- R6: `op_i[3:2]` = 10 is an arithmetic right shift: vacated upper bits become copies of `data_i[63]`.
- R7: `op_i[3:2]` = 00 is a logical left shift: vacated lower bits become 0.
- R8: `op_i[3:2]` = 11 is a right rotate by n: the result is (x >> n) | (x << (64 − n)).
- R9: A rotate with a distance of 0 returns `data_i` unchanged.
- R10: Any code with `op_i[1:0]` = 11 (3, 7, 11 and 15) produces a result of 0.
- R11: With `REG_OUT` = 1 the result appears on `result_o` one rising clock edge after the inputs are sampled. `result_o` is 0 while `rst_ni` is low, and an asynchronous reset clears it at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code: [3:2] selects the operation, [1:0] selects the amount source |
| data_i | input | 64 | Operand that is shifted or rotated |
| amt_reg_i | input | 64 | Amount register for the variable forms; only bits 5:0 are used |
| imm_i | input | 5 | Immediate shift distance |
| result_o | output | 64 | Shift or rotate result |

## Verification
The bench sweeps all 64 distances for every operation and both immediate ranges, so it catches four kinds of error. A left shift whose rotate amount is not negated gives mirrored results. An offset form that drops the +32 lands in the wrong half of the word. An arithmetic shift that fills with zeros loses negative values. A rotate by zero that returns zero, or that uses the wrong operand, corrupts the identity case. Directed vectors set the high bits of the amount register and expect no change in the result, which shows up a design that masks to too many bits. They also drive the unused codes with all-ones data, which shows up a design that lets those codes through. A mid-run reset checks that the output register clears without waiting for a clock edge.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [1:0] {
    K_SLL  = 2'b00,
    K_SRL  = 2'b01,
    K_SRA  = 2'b10,
    K_ROTR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    S_IMM   = 2'b00,
    S_IMM32 = 2'b01,
    S_VAR   = 2'b10,
    S_BAD   = 2'b11
  } amt_src_e;
endpackage

// File: rtl/amt_select.sv
module amt_select
  import shift_unit_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  amt_src_e         src_i,
  input  logic [AW-2:0]    imm_i,
  input  logic [AW-1:0]    reg_amt_i,
  output logic [AW-1:0]    amt_o,
  output logic             bad_o
);
  always_comb begin
    amt_o = '0;
    bad_o = 1'b0;
    unique case (src_i)
      S_IMM:   amt_o = {1'b0, imm_i};
      S_IMM32: amt_o = {1'b1, imm_i};  // imm + half word width
      S_VAR:   amt_o = reg_amt_i;
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rotr_barrel.sv
module rotr_barrel #(
  parameter int unsigned W  = 64,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] rot_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = rot_i[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
  end

  assign data_o = stage[AW];
endmodule

// File: rtl/shift_finish.sv
module shift_finish
  import shift_unit_pkg::*;
#(
  parameter int unsigned W  = 64,
  parameter int unsigned AW = $clog2(W)
) (
  input  shift_kind_e   kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          sign_i,
  input  logic [W-1:0]  rot_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] keep_mask;

  always_comb begin
    unique case (kind_i)
      K_SLL:         keep_mask = {W{1'b1}} << amt_i;
      K_SRL, K_SRA:  keep_mask = {W{1'b1}} >> amt_i;
      default:       keep_mask = {W{1'b1}};
    endcase
  end

  always_comb begin
    res_o = rot_i & keep_mask;
    if (kind_i == K_SRA && sign_i) res_o = res_o | ~keep_mask;
  end
endmodule

// File: rtl/shift_rot64_unit.sv
module shift_rot64_unit
  import shift_unit_pkg::*;
#(
  parameter int unsigned W       = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  amt_reg_i,
  input  logic [$clog2(W)-2:0] imm_i,
  output logic [W-1:0]  result_o
);
  localparam int unsigned AW = $clog2(W);

  shift_kind_e  kind;
  amt_src_e     src;
  logic [AW-1:0] amt;
  logic [AW-1:0] rot_amt;
  logic          bad_code;
  logic [W-1:0]  rotated;
  logic [W-1:0]  shaped;
  logic [W-1:0]  res_d;
  logic          unused_amt_hi;

  assign kind = shift_kind_e'(op_i[3:2]);
  assign src  = amt_src_e'(op_i[1:0]);
  assign unused_amt_hi = ^amt_reg_i[W-1:AW];

  amt_select #(.AW(AW)) i_amt_select (
    .src_i     (src),
    .imm_i     (imm_i),
    .reg_amt_i (amt_reg_i[AW-1:0]),
    .amt_o     (amt),
    .bad_o     (bad_code)
  );

  // left shift = right rotate by (W - n) mod W
  assign rot_amt = (kind == K_SLL) ? AW'(0) - amt : amt;

  rotr_barrel #(.W(W), .AW(AW)) i_rotr_barrel (
    .data_i (data_i),
    .rot_i  (rot_amt),
    .data_o (rotated)
  );

  shift_finish #(.W(W), .AW(AW)) i_shift_finish (
    .kind_i (kind),
    .amt_i  (amt),
    .sign_i (data_i[W-1]),
    .rot_i  (rotated),
    .res_o  (shaped)
  );

  assign res_d = bad_code ? '0 : shaped;

  // R2
  imm32_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src == S_IMM32 |-> amt >= AW'(W/2));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) result_o <= '0;
      else         result_o <= res_d;
    end

    // R10
    bad_code_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && src == S_BAD) |=> result_o == '0);
    // R5
    srl_msb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && kind == K_SRL && src != S_BAD && amt != '0) |=> !result_o[W-1]);
    // R6
    sra_sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && kind == K_SRA && src != S_BAD) |=> result_o[W-1] == $past(data_i[W-1]));
    // R8
    rotr_popcount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && kind == K_ROTR && src != S_BAD)
        |=> $countones(result_o) == $countones($past(data_i)));
    // R9
    rotr_zero_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && kind == K_ROTR && src != S_BAD && amt == '0) |=> result_o == $past(data_i));
  end else begin : g_comb
    assign result_o = res_d;

    // R10
    bad_code_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src == S_BAD |-> result_o == '0);
    // R9
    rotr_zero_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind == K_ROTR && src != S_BAD && amt == '0) |-> result_o == data_i);
  end
endmodule

// File: tb/test_shift_rot64_unit.sv
module test_shift_rot64_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] data_i = '0;
  logic [63:0] amt_reg_i = '0;
  logic [4:0]  imm_i = '0;
  logic [63:0] result_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  shift_rot64_unit i_shift_rot64_unit (
    .clk_i, .rst_ni, .op_i, .data_i, .amt_reg_i, .imm_i, .result_o
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] data;
    logic [63:0] amt;
    logic [4:0]  imm;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 64'h1, 64'h0, 5'd4, 64'h10},                                   // R1 R7
    '{4'h1, 64'h1, 64'h0, 5'd0, 64'h0000_0001_0000_0000},                  // R2 R7
    '{4'h4, 64'h8000_0000_0000_0000, 64'h0, 5'd31, 64'h0000_0001_0000_0000}, // R1 R5
    '{4'h5, 64'h8000_0000_0000_0000, 64'h0, 5'd31, 64'h1},                 // R2 R5
    '{4'h8, 64'h8000_0000_0000_0000, 64'h0, 5'd4, 64'hF800_0000_0000_0000},  // R6
    '{4'h9, 64'hF000_0000_0000_0000, 64'h0, 5'd0, 64'hFFFF_FFFF_F000_0000},  // R2 R6
    '{4'hA, 64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFC1, 5'd9, 64'h2000_0000_0000_0000}, // R3 R6
    '{4'hC, 64'h1, 64'h0, 5'd1, 64'h8000_0000_0000_0000},                  // R8
    '{4'hD, 64'h0000_0000_FFFF_FFFF, 64'h0, 5'd0, 64'hFFFF_FFFF_0000_0000},  // R2 R8
    '{4'hE, 64'h1234_5678_9ABC_DEF0, 64'h40, 5'd3, 64'h1234_5678_9ABC_DEF0}, // R3 R9
    '{4'hC, 64'h0000_0000_DEAD_BEEF, 64'h0, 5'd0, 64'h0000_0000_DEAD_BEEF},  // R9
    '{4'h2, 64'hFF, 64'h7, 5'd20, 64'h7F80},                                // R3 R4 R7
    '{4'h6, 64'hFF00, 64'h108, 5'd1, 64'hFF},                               // R3 R4 R5
    '{4'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd5, 64'h0},                   // R10
    '{4'h7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd5, 64'h0},                   // R10
    '{4'hB, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd5, 64'h0},                   // R10
    '{4'hF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd5, 64'h0}                    // R10
  };

  function automatic logic [63:0] ref_model(logic [3:0] op, logic [63:0] d,
                                            logic [63:0] a, logic [4:0] im);
    int n;
    case (op[1:0])
      2'b00:   n = int'(im);
      2'b01:   n = int'(im) + 32;
      2'b10:   n = int'(a[5:0]);
      default: return 64'h0;
    endcase
    case (op[3:2])
      2'b00:   return d << n;
      2'b01:   return d >> n;
      2'b10:   return 64'($signed(d) >>> n);
      default: return (n == 0) ? d : ((d >> n) | (d << (64 - n)));
    endcase
  endfunction

  task automatic check(logic [63:0] exp, string req);
    n_vec++;
    if (result_o !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%h data=%h amt=%h imm=%0d got %h expected %h",
               req, op_i, data_i, amt_reg_i, imm_i, result_o, exp);
    end
  endtask

  // drive on a falling edge, result registered at next rising edge, sample at next falling
  task automatic apply(logic [3:0] op, logic [63:0] d, logic [63:0] a, logic [4:0] im,
                       logic [63:0] exp, string req);
    @(negedge clk_i);
    op_i = op; data_i = d; amt_reg_i = a; imm_i = im;
    @(negedge clk_i);
    check(exp, req);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    op_i = 4'hC; data_i = 64'hA5A5_A5A5_A5A5_A5A5;
    repeat (3) @(negedge clk_i);
    check(64'h0, "R11 reset");
    rst_ni = 1'b1;

    foreach (VEC[i])
      apply(VEC[i].op, VEC[i].data, VEC[i].amt, VEC[i].imm, VEC[i].exp, "R1-table");

    // every distance, every operation, variable form (R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 64; n++) begin
        logic [63:0] d = {$urandom, $urandom};
        logic [63:0] a = {$urandom, $urandom};
        a[5:0] = 6'(n);
        apply({2'(k), 2'b10}, d, a, 5'(n), ref_model({2'(k), 2'b10}, d, a, 5'(n)),
              "R3 var sweep");
      end
    end

    // immediate and offset forms, all immediates (R1 R2)
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < 32; n++) begin
          logic [63:0] d = {$urandom, $urandom};
          logic [63:0] a = {$urandom, $urandom};
          apply({2'(k), 2'(s)}, d, a, 5'(n), ref_model({2'(k), 2'(s)}, d, a, 5'(n)),
                s == 0 ? "R1 imm sweep" : "R2 imm32 sweep");
        end
      end
    end

    // random codes including unused ones (R10)
    for (int r = 0; r < 300; r++) begin
      logic [3:0]  op = 4'($urandom);
      logic [63:0] d  = {$urandom, $urandom};
      logic [63:0] a  = {$urandom, $urandom};
      logic [4:0]  im = 5'($urandom);
      apply(op, d, a, im, ref_model(op, d, a, im), "R10 random");
    end

    // R11 one-cycle latency: output holds previous value before the edge
    @(negedge clk_i);
    op_i = 4'h0; data_i = 64'h1; imm_i = 5'd1;
    @(negedge clk_i);
    check(64'h2, "R11 latency first");
    op_i = 4'h0; data_i = 64'h1; imm_i = 5'd3;
    @(posedge clk_i);
    #1;
    check(64'h8, "R11 latency second");

    // R11 asynchronous reset mid-run
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check(64'h0, "R11 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule